// File: doc/BRIEF.md
# Dual-Mode Processor Timer Array

This block holds a parameterised array of per-processor timers and one mode register that software reaches through the system timer window. Each processor timer can run in one of two modes.

In counter mode, a timer compares a 22-bit count against a programmable limit. When the count reaches the limit, the timer wraps, raises a reached flag and drives an interrupt line to its own processor. In user mode, the same timer becomes a free-running 63-bit counter. Software reads and loads that counter as two 32-bit words, starts and stops it through a status word, and the timer never interrupts.

All timers advance on a shared `tick` pulse that stands for one 500 ns period. The count occupies bit 9 upward, so the low nine bits of any count word read as zero. Register access is a single-cycle strobe bus with a window select and a word offset. Read data is registered and appears the cycle after the read strobe.

Top module: `ptmr_array`

## Requirements
- R1: After reset the mode word reads 0, every processor timer reports running (status word 3 = 1), its limit word and count word read 0, and every interrupt line is low.
- R2: The mode word sits at word offset 4 of the system window (`winSel` = 0). Bit i selects user mode for processor i. Bits at or above `NUM_CPU` read as zero. A write to offset 4 through a processor window (`winSel` = i+1) leaves the mode word unchanged.
- R3: When a mode bit changes from 0 to 1, the same clock edge lowers that processor's interrupt, stops it (status reads 0), clears its count and reached flag, and forces its limit to the maximum value, so the limit word reads 0x7FFFFE00 once the timer is back in counter mode.
- R4: When a mode bit changes from 1 to 0, the timer restarts in counter mode with running = 1 and the count and reached flag at 0.
- R5: In user mode, word 0 reads {reached in bit 31, count bits 62..32 in bits 30..0} and word 1 reads count bits 31..9 in bits 31..9 with bits 8..0 zero. Writing word 0 or word 1 loads that half of the count and clears reached.
- R6: A running user-mode timer adds 1 at bit 9 on each tick, and the carry passes from word 1 into word 0.
- R7: In user mode, writing status word 3 with bit 0 = 1 starts the timer and with bit 0 = 0 stops it. Writing the state that already holds changes neither the count nor the running flag. Status reads return the running flag for a processor window and 0 for the system window.
- R8: A user-mode timer never asserts its interrupt. When it overflows past the all-ones count, it wraps to 0 and sets reached (bit 31 of word 0).
- R9: In counter mode, a word 0 write loads the limit from bits 30..9 and resets the count to 0. Word 1 reads {reached in bit 31, count in bits 30..9}. On the tick where the count would equal a non-zero limit, the count goes to 0 and both reached and the interrupt are set. A read of word 0 returns the limit and clears reached and the interrupt.
- R10: With a limit of 0, a counter-mode timer runs freely, with no reached flag and no interrupt.
- R11: In counter mode, a write to word 2 loads the limit without changing the count.
- R12: If a limit match falls on the same edge as a word 0 acknowledge read, reached and the interrupt stay set. If a user-mode word load falls on the same edge as a tick, the loaded value holds and that tick is dropped.
- R13: In counter mode, writes to word 1 and to status word 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse for each 500 ns count period |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| winSel | input | SEL_W | 0 selects the system window; i+1 selects processor i |
| wordOff | input | 3 | Word offset inside the window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| irq | output | NUM_CPU | Per-processor interrupt lines |

## Verification
Two pairs of events can land on the same edge, and both are provoked on purpose. The first pair is a counter-mode limit match and the acknowledging read of the limit word. The bench counts the timer to one tick short of its limit, then raises `tick` and the word 0 read strobe in the same cycle. It expects the interrupt and the reached bit to survive the read. The second pair is a user-mode word load and a tick: the bench writes word 1 of a running user timer in the tick cycle and expects the loaded value to read back unchanged.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  localparam int WORD_W   = 32;
  localparam int TICK_BIT = 9;                  // count unit sits at bit 9
  localparam int CNT_W    = 63 - TICK_BIT;      // user-mode count units
  localparam int CMP_W    = 31 - TICK_BIT;      // counter-mode count units
  localparam int LO_U     = WORD_W - TICK_BIT;  // units held by the low word
  localparam int HI_U     = CNT_W - LO_U;       // units held by the high word

  localparam logic [2:0] WO_LIMIT      = 3'd0;
  localparam logic [2:0] WO_COUNT      = 3'd1;
  localparam logic [2:0] WO_LIMIT_KEEP = 3'd2;
  localparam logic [2:0] WO_STATUS     = 3'd3;
  localparam logic [2:0] WO_MODE       = 3'd4;

  typedef struct packed {
    logic limLoadRst;
    logic limLoadKeep;
    logic ackRead;
    logic hiLoad;
    logic loLoad;
    logic runSet;
    logic runClr;
    logic enterUser;
    logic leaveUser;
  } tmrStrobe_t;

  typedef struct packed {
    logic [WORD_W-1:0] limWord;
    logic [WORD_W-1:0] cntWord;
    logic [WORD_W-1:0] hiWord;
    logic [WORD_W-1:0] loWord;
    logic              running;
  } tmrView_t;
endpackage

// File: rtl/ptmr_dp.sv
`timescale 1ns/1ps
module ptmr_dp
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              userMode,
  input  tmrStrobe_t        stb,
  input  logic [WORD_W-1:0] wrData,
  output tmrView_t          view,
  output logic              irq
);
  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] limU;
  logic             reached;
  logic             running;

  logic [CMP_W-1:0] cmpNext;
  logic             limHit;
  logic             cntMax;
  logic             reachNow;

  always_comb begin
    cmpNext  = cnt[CMP_W-1:0] + 1'b1;
    limHit   = (limU != '0) && (cmpNext == limU);
    cntMax   = &cnt;
    reachNow = !userMode && !stb.enterUser && !stb.leaveUser &&
               !stb.limLoadRst && !stb.limLoadKeep && tick && running && limHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      limU    <= '0;
      reached <= 1'b0;
      running <= 1'b1;
      irq     <= 1'b0;
    end else if (stb.enterUser) begin
      irq     <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
      reached <= 1'b0;
      limU    <= '1;
    end else if (stb.leaveUser) begin
      running <= 1'b1;
      cnt     <= '0;
      reached <= 1'b0;
    end else if (userMode) begin
      if (stb.hiLoad) begin
        cnt[CNT_W-1:LO_U] <= wrData[HI_U-1:0];
        reached           <= 1'b0;
      end else if (stb.loLoad) begin
        cnt[LO_U-1:0] <= wrData[WORD_W-1:TICK_BIT];
        reached       <= 1'b0;
      end else if (tick && running) begin
        if (cntMax) begin
          cnt     <= '0;
          reached <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (stb.runSet) running <= 1'b1;
      if (stb.runClr) running <= 1'b0;
    end else begin
      if (stb.limLoadRst) begin
        limU <= wrData[WORD_W-2:TICK_BIT];
        cnt  <= '0;
        irq  <= 1'b0;
      end else if (stb.limLoadKeep) begin
        limU <= wrData[WORD_W-2:TICK_BIT];
      end else if (tick && running) begin
        if (limHit) cnt[CMP_W-1:0] <= '0;
        else        cnt[CMP_W-1:0] <= cmpNext;
      end
      if (reachNow) begin
        reached <= 1'b1;
        irq     <= 1'b1;
      end else if (stb.ackRead) begin
        reached <= 1'b0;
        irq     <= 1'b0;
      end
    end
  end

  always_comb begin
    view.limWord = {1'b0, limU, {TICK_BIT{1'b0}}};
    view.cntWord = {reached, cnt[CMP_W-1:0], {TICK_BIT{1'b0}}};
    view.hiWord  = {reached, cnt[CNT_W-1:LO_U]};
    view.loWord  = {cnt[LO_U-1:0], {TICK_BIT{1'b0}}};
    view.running = running;
  end
endmodule

// File: rtl/ptmr_ctrl.sv
`timescale 1ns/1ps
module ptmr_ctrl
  import ptmr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int SEL_W   = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [SEL_W-1:0]               winSel,
  input  logic [2:0]                     wordOff,
  input  logic [NUM_CPU-1:0]             modeData,
  input  tmrView_t   [NUM_CPU-1:0]       views,
  output tmrStrobe_t [NUM_CPU-1:0]       strobes,
  output logic [NUM_CPU-1:0]             modeBits,
  output logic [WORD_W-1:0]              rdData
);
  logic               sysHit;
  logic               modeWr;
  logic [NUM_CPU-1:0] hitVec;
  logic [WORD_W-1:0]  modeWord;
  logic [WORD_W-1:0]  rdNext;

  assign sysHit = (winSel == '0);
  assign modeWr = wrEn && sysHit && (wordOff == WO_MODE);

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_dec
    logic wrHit;
    logic user;
    assign hitVec[i] = (winSel == SEL_W'(i + 1));
    assign wrHit     = wrEn && hitVec[i];
    assign user      = modeBits[i];
    always_comb begin
      strobes[i].limLoadRst  = wrHit && (wordOff == WO_LIMIT) && !user;
      strobes[i].limLoadKeep = wrHit && (wordOff == WO_LIMIT_KEEP) && !user;
      strobes[i].ackRead     = rdEn && hitVec[i] && (wordOff == WO_LIMIT) && !user;
      strobes[i].hiLoad      = wrHit && (wordOff == WO_LIMIT) && user;
      strobes[i].loLoad      = wrHit && (wordOff == WO_COUNT) && user;
      strobes[i].runSet      = wrHit && (wordOff == WO_STATUS) && user && modeData[0];
      strobes[i].runClr      = wrHit && (wordOff == WO_STATUS) && user && !modeData[0];
      strobes[i].enterUser   = modeWr && modeData[i] && !modeBits[i];
      strobes[i].leaveUser   = modeWr && !modeData[i] && modeBits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)       modeBits <= '0;
    else if (modeWr) modeBits <= modeData;
  end

  always_comb begin
    modeWord = '0;
    modeWord[NUM_CPU-1:0] = modeBits;
  end

  always_comb begin
    rdNext = '0;
    if (sysHit && (wordOff == WO_MODE)) rdNext = modeWord;
    for (int i = 0; i < NUM_CPU; i++) begin
      if (hitVec[i]) begin
        case (wordOff)
          WO_LIMIT:  rdNext = modeBits[i] ? views[i].hiWord : views[i].limWord;
          WO_COUNT:  rdNext = modeBits[i] ? views[i].loWord : views[i].cntWord;
          WO_STATUS: rdNext = {{(WORD_W-1){1'b0}}, views[i].running};
          default:   rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
    else           rdData <= '0;
  end
endmodule

// File: rtl/ptmr_array.sv
`timescale 1ns/1ps
module ptmr_array
  import ptmr_pkg::*;
#(
  parameter int NUM_CPU = 4,
  localparam int SEL_W  = $clog2(NUM_CPU + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [SEL_W-1:0]   winSel,
  input  logic [2:0]         wordOff,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic [NUM_CPU-1:0] irq
);
  tmrStrobe_t [NUM_CPU-1:0] strobes;
  tmrView_t   [NUM_CPU-1:0] views;
  logic [NUM_CPU-1:0]       modeBits;
  logic [NUM_CPU-1:0]       runVec;

  ptmr_ctrl #(.NUM_CPU(NUM_CPU), .SEL_W(SEL_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .winSel   (winSel),
    .wordOff  (wordOff),
    .modeData (wrData[NUM_CPU-1:0]),
    .views    (views),
    .strobes  (strobes),
    .modeBits (modeBits),
    .rdData   (rdData)
  );

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_tmr
    ptmr_dp u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (tick),
      .userMode (modeBits[i]),
      .stb      (strobes[i]),
      .wrData   (wrData),
      .view     (views[i]),
      .irq      (irq[i])
    );
    assign runVec[i] = views[i].running;
  end
endmodule

// File: rtl/ptmr_chk.sv
`timescale 1ns/1ps
module ptmr_chk #(
  parameter int NUM_CPU = 4,
  parameter int SEL_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [SEL_W-1:0]   winSel,
  input logic [2:0]         wordOff,
  input logic [NUM_CPU-1:0] irq,
  input logic [NUM_CPU-1:0] modeBits,
  input logic [NUM_CPU-1:0] runVec
);
  // R8: a timer in user mode keeps its interrupt low
  p_user_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(|(irq & modeBits)));

  // R2: mode writes through a processor window leave the mode word alone
  p_mode_guard_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (winSel != '0) && (wordOff == 3'd4)) |=> $stable(modeBits));

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_prop
    // R3: entering user mode stops the timer
    p_enter_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(modeBits[i]) |-> !runVec[i]);
    // R4: leaving user mode restarts the timer
    p_leave_run_r4: assert property (@(posedge clk) disable iff (!rstN)
      $fell(modeBits[i]) |-> runVec[i]);
    // R7/R13: a counter-mode timer always runs
    p_counter_runs_r13: assert property (@(posedge clk) disable iff (!rstN)
      !modeBits[i] |-> runVec[i]);
  end
endmodule

bind ptmr_array ptmr_chk #(.NUM_CPU(NUM_CPU), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .winSel   (winSel),
  .wordOff  (wordOff),
  .irq      (irq),
  .modeBits (modeBits),
  .runVec   (runVec)
);

// File: tb/ptmr_array_tb.sv
`timescale 1ns/1ps
module ptmr_array_tb;
  localparam int NCPU = 4;
  localparam int SW   = $clog2(NCPU + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            tick = 1'b0;
  logic            wrEn = 1'b0;
  logic            rdEn = 1'b0;
  logic [SW-1:0]   winSel = '0;
  logic [2:0]      wordOff = '0;
  logic [31:0]     wrData = '0;
  logic [31:0]     rdData;
  logic [NCPU-1:0] irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  ptmr_array #(.NUM_CPU(NCPU)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .winSel(winSel), .wordOff(wordOff), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [2:0] off, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; winSel = SW'(sel); wordOff = off; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int sel, input logic [2:0] off, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; winSel = SW'(sel); wordOff = off;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 3'd4, v); chk("R1 mode word", v, 32'h0);
    rd(1, 3'd3, v); chk("R1 status", v, 32'h1);
    rd(1, 3'd1, v); chk("R1 count", v, 32'h0);
    rd(1, 3'd0, v); chk("R1 limit", v, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_mode_reg();
    logic [31:0] v;
    wr(0, 3'd4, 32'hFFFF_FFF5);
    rd(0, 3'd4, v); chk("R2 mode bits", v, 32'h5);
    wr(2, 3'd4, 32'h0);
    rd(0, 3'd4, v); chk("R2 cpu window mode write ignored", v, 32'h5);
    wr(0, 3'd4, 32'h0);
    rd(0, 3'd4, v); chk("R2 mode cleared", v, 32'h0);
  endtask

  task automatic t_counter();
    logic [31:0] v;
    wr(1, 3'd0, 32'h0000_0A00);
    ticks(4);
    rd(1, 3'd1, v); chk("R9 count before limit", v, 32'h0000_0800);
    chk("R9 irq low before limit", {31'h0, irq[0]}, 32'h0);
    ticks(1);
    chk("R9 irq at limit", {31'h0, irq[0]}, 32'h1);
    rd(1, 3'd1, v); chk("R9 reached and wrap", v, 32'h8000_0000);
    rd(1, 3'd0, v); chk("R9 limit read", v, 32'h0000_0A00);
    chk("R9 irq cleared by read", {31'h0, irq[0]}, 32'h0);
    rd(1, 3'd1, v); chk("R9 reached cleared", v, 32'h0);
  endtask

  task automatic t_keep_and_ignore();
    logic [31:0] v;
    ticks(3);
    wr(1, 3'd2, 32'h0000_1000);
    rd(1, 3'd1, v); chk("R11 count kept", v, 32'h0000_0600);
    wr(1, 3'd1, 32'h1234_5600);
    wr(1, 3'd3, 32'h0);
    rd(1, 3'd1, v); chk("R13 count write ignored", v, 32'h0000_0600);
    rd(1, 3'd3, v); chk("R13 status write ignored", v, 32'h1);
    ticks(4);
    chk("R11 no irq yet", {31'h0, irq[0]}, 32'h0);
    ticks(1);
    chk("R11 irq at new limit", {31'h0, irq[0]}, 32'h1);
    rd(1, 3'd0, v);
  endtask

  task automatic t_free_run();
    logic [31:0] v;
    wr(2, 3'd0, 32'h0);
    ticks(10);
    rd(2, 3'd1, v); chk("R10 free run count", v, 32'h0000_1400);
    chk("R10 no irq", {31'h0, irq[1]}, 32'h0);
  endtask

  task automatic t_ack_collision();
    logic [31:0] v;
    wr(1, 3'd0, 32'h0000_0A00);
    ticks(4);
    @(negedge clk);
    rdEn = 1'b1; winSel = SW'(1); wordOff = 3'd0; tick = 1'b1;
    @(negedge clk);
    rdEn = 1'b0; tick = 1'b0;
    chk("R12 irq survives ack", {31'h0, irq[0]}, 32'h1);
    rd(1, 3'd1, v); chk("R12 reached survives ack", v, 32'h8000_0000);
    rd(1, 3'd0, v);
  endtask

  task automatic t_enter_user();
    logic [31:0] v;
    wr(3, 3'd0, 32'h0000_0400);
    ticks(2);
    chk("R9 irq proc2", {31'h0, irq[2]}, 32'h1);
    wr(0, 3'd4, 32'h4);
    chk("R3 irq lowered", {31'h0, irq[2]}, 32'h0);
    rd(3, 3'd3, v); chk("R3 stopped", v, 32'h0);
    ticks(3);
    rd(3, 3'd1, v); chk("R3 low word zero", v, 32'h0);
    rd(3, 3'd0, v); chk("R3 high word zero", v, 32'h0);
  endtask

  task automatic t_start_stop();
    logic [31:0] v;
    wr(3, 3'd3, 32'h1);
    rd(3, 3'd3, v); chk("R7 started", v, 32'h1);
    ticks(3);
    wr(3, 3'd3, 32'h1);
    rd(3, 3'd1, v); chk("R7 repeat start no effect", v, 32'h0000_0600);
    wr(3, 3'd3, 32'h0);
    ticks(2);
    rd(3, 3'd1, v); chk("R7 stopped holds", v, 32'h0000_0600);
    wr(3, 3'd3, 32'h0);
    rd(3, 3'd3, v); chk("R7 repeat stop", v, 32'h0);
    rd(0, 3'd3, v); chk("R7 system status zero", v, 32'h0);
  endtask

  task automatic t_user_words();
    logic [31:0] v;
    wr(3, 3'd0, 32'h0000_0012);
    wr(3, 3'd1, 32'hABCD_E1FF);
    rd(3, 3'd1, v); chk("R5 low word", v, 32'hABCD_E000);
    rd(3, 3'd0, v); chk("R5 high word", v, 32'h0000_0012);
    wr(3, 3'd1, 32'hFFFF_FC00);
    wr(3, 3'd3, 32'h1);
    ticks(2);
    wr(3, 3'd3, 32'h0);
    rd(3, 3'd1, v); chk("R6 carry low", v, 32'h0);
    rd(3, 3'd0, v); chk("R6 carry high", v, 32'h0000_0013);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(3, 3'd0, 32'h7FFF_FFFF);
    wr(3, 3'd1, 32'hFFFF_FE00);
    wr(3, 3'd3, 32'h1);
    ticks(1);
    wr(3, 3'd3, 32'h0);
    rd(3, 3'd0, v); chk("R8 reached on overflow", v, 32'h8000_0000);
    rd(3, 3'd1, v); chk("R8 low wrapped", v, 32'h0);
    chk("R8 no irq", {31'h0, irq[2]}, 32'h0);
    wr(3, 3'd1, 32'h0);
    rd(3, 3'd0, v); chk("R5 load clears reached", v, 32'h0);
  endtask

  task automatic t_load_collision();
    logic [31:0] v;
    wr(3, 3'd3, 32'h1);
    @(negedge clk);
    wrEn = 1'b1; winSel = SW'(3); wordOff = 3'd1; wrData = 32'h0000_0400; tick = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
    wr(3, 3'd3, 32'h0);
    rd(3, 3'd1, v); chk("R12 load beats tick", v, 32'h0000_0400);
  endtask

  task automatic t_leave_user();
    logic [31:0] v;
    wr(0, 3'd4, 32'h0);
    rd(3, 3'd3, v); chk("R4 running again", v, 32'h1);
    rd(3, 3'd1, v); chk("R4 count reset", v, 32'h0);
    ticks(2);
    rd(3, 3'd1, v); chk("R4 counting", v, 32'h0000_0400);
    rd(3, 3'd0, v); chk("R3 limit forced to max", v, 32'h7FFF_FE00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mode_reg();
    t_counter();
    t_keep_and_ignore();
    t_free_run();
    t_ack_collision();
    t_enter_user();
    t_start_stop();
    t_user_words();
    t_overflow();
    t_load_collision();
    t_leave_user();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule